// File: doc/BRIEF.md
# Single-Cycle Shift and Bit-Field Unit

This unit is the shift stage of a fixed-point signal-processing datapath. Each cycle it takes an operation code, a 32-bit data operand `a_i`, a control operand `b_i` and a base word `c_i`. `b_i` carries either a signed shift amount or a field position and length. The unit covers several groups of operations:

- logical shifts, arithmetic shifts and rotates
- setting, clearing, toggling and testing a single bit
- extracting a bit field, with or without sign extension
- depositing a bit field into a base word
- deriving an exponent by counting redundant sign bits

There are no internal pipeline stages. The combinational result and two flags are captured in an output register on every rising clock edge, so a neighbouring unit can consume the value on the next cycle. Upper bits of `b_i` that the selected operation does not use have no effect.

Top module: `fieldshift`

## Requirements
- R1: While `rst_n` is low, the outputs are `res_o = 0`, `zero_o = 1` and `ovf_o = 0`.
- R2: The inputs present at a rising edge determine the outputs right after that edge. Between edges the outputs keep their value.
- R3: Op 0 is a logical shift by the signed amount in `b_i[7:0]`. A positive amount shifts left and a negative amount shifts right. A magnitude of 32 or more gives 0.
- R4: Op 1 is an arithmetic shift. A right shift fills with the sign bit, and a magnitude of 32 or more gives 32 copies of the sign. A left shift gives the same result as a logical left shift.
- R5: Op 2 rotates `a_i` left by `b_i[4:0]`, which is the amount modulo 32, so -1 rotates right by one.
- R6: Ops 3, 4 and 5 set, clear and toggle bit `b_i[4:0]` of `a_i`. All other bits pass through unchanged.
- R7: Op 6 tests a bit. The result holds bit `b_i[4:0]` of `a_i` in bit 0, and its upper 31 bits are zero.
- R8: A field starts at position `b_i[4:0]` and has length `b_i[13:8]` (0 to 63). The effective length is the smaller of that length and 32 minus the position. A length of 0 is an empty field.
- R9: Op 7 extracts the field of `a_i`, right-justified and zero-extended. Op 8 does the same but copies the top bit of the field into all higher bits. An empty field gives 0 for both.
- R10: Op 9 returns `c_i` with the field replaced by the low bits of `a_i`. An empty field returns `c_i` unchanged.
- R11: Op 10 returns the count of leading bits of `a_i` that equal bit 31, minus one. An all-zero or all-ones operand gives 31.
- R12: `zero_o` is 1 exactly when the registered result is 0. `ovf_o` is 1 only for op 1 with a positive amount whose result bit 31 differs from `a_i[31]`. Ops 11 to 15 pass `a_i` through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Data operand |
| b_i | input | 32 | Shift amount in [7:0]; field position in [4:0] and length in [13:8] |
| c_i | input | 32 | Base word for field deposit |
| res_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered flag, result is zero |
| ovf_o | output | 1 | Registered flag, sign changed on arithmetic left shift |

## Verification
Shifts are tried with small positive and negative amounts, with 31, and with magnitudes of 32, 40 and 128. These separate the direction decoding from the saturation path, and the logical fill from the arithmetic fill. Field operations use positions whose length runs past bit 31, lengths of 0 and 32, and fields whose top bit is set or clear, which exposes clipping, mask-edge and sign-copy errors. Exponent operands sit at both extremes and one bit in from each end, so an off-by-one in the sign-run count cannot hide.

// File: rtl/fieldshift.sv
module fieldshift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         ovf_o
);
  localparam int PW = $clog2(W);
  localparam int LW = PW + 1;

  localparam logic [3:0] OP_LSH  = 4'd0;
  localparam logic [3:0] OP_ASH  = 4'd1;
  localparam logic [3:0] OP_ROT  = 4'd2;
  localparam logic [3:0] OP_BSET = 4'd3;
  localparam logic [3:0] OP_BCLR = 4'd4;
  localparam logic [3:0] OP_BTGL = 4'd5;
  localparam logic [3:0] OP_BTST = 4'd6;
  localparam logic [3:0] OP_FEXT = 4'd7;
  localparam logic [3:0] OP_FSXT = 4'd8;
  localparam logic [3:0] OP_FDEP = 4'd9;
  localparam logic [3:0] OP_EXP  = 4'd10;

  logic unused_hi;
  assign unused_hi = ^b_i[W-1:8+LW];

  // shift amount: signed, magnitude saturates at W
  logic [7:0]    amt, mag;
  logic          neg, big;
  logic [PW-1:0] sh;
  assign amt = b_i[7:0];
  assign neg = amt[7];
  assign mag = neg ? (~amt + 8'd1) : amt;
  assign big = (mag >= 8'(W));
  assign sh  = mag[PW-1:0];

  logic [W-1:0] shl, shr, sar, rot;
  assign shl = big ? '0 : (a_i << sh);
  assign shr = big ? '0 : (a_i >> sh);
  assign sar = big ? {W{a_i[W-1]}} : W'($signed(a_i) >>> sh);
  assign rot = (a_i << amt[PW-1:0]) | (a_i >> (LW'(W) - {1'b0, amt[PW-1:0]}));

  // field geometry with clipping at the top bit
  logic [PW-1:0] pos;
  logic [LW-1:0] len_raw, room, flen, topidx;
  logic [W:0]    one_sh;
  logic [W-1:0]  fmask, fld, dmask, bmask;
  logic          fsgn;
  assign pos     = b_i[PW-1:0];
  assign len_raw = b_i[8+LW-1:8];
  assign room    = LW'(W) - {1'b0, pos};
  assign flen    = (len_raw > room) ? room : len_raw;
  assign one_sh  = (W+1)'(1) << flen;
  assign fmask   = W'(one_sh - (W+1)'(1));
  assign fld     = (a_i >> pos) & fmask;
  assign topidx  = {1'b0, pos} + flen - LW'(1);
  assign fsgn    = (flen != '0) && a_i[topidx[PW-1:0]];
  assign dmask   = fmask << pos;
  assign bmask   = W'(1) << pos;

  // redundant sign bit count
  logic [LW-1:0] sgn_run;
  always_comb begin
    logic run;
    run     = 1'b1;
    sgn_run = '0;
    for (int i = W - 2; i >= 0; i--) begin
      if (run && (a_i[i] == a_i[W-1])) sgn_run = sgn_run + LW'(1);
      else run = 1'b0;
    end
  end

  logic [W-1:0] res_n;
  always_comb begin
    case (op_i)
      OP_LSH:  res_n = neg ? shr : shl;
      OP_ASH:  res_n = neg ? sar : shl;
      OP_ROT:  res_n = rot;
      OP_BSET: res_n = a_i | bmask;
      OP_BCLR: res_n = a_i & ~bmask;
      OP_BTGL: res_n = a_i ^ bmask;
      OP_BTST: res_n = W'(a_i[pos]);
      OP_FEXT: res_n = fld;
      OP_FSXT: res_n = fld | (fsgn ? ~fmask : '0);
      OP_FDEP: res_n = (c_i & ~dmask) | ((a_i << pos) & dmask);
      OP_EXP:  res_n = W'(sgn_run);
      default: res_n = a_i;
    endcase
  end

  logic ovf_n;
  assign ovf_n = (op_i == OP_ASH) && !neg && (amt != 8'd0) && (res_n[W-1] != a_i[W-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_o  <= '0;
      zero_o <= 1'b1;
      ovf_o  <= 1'b0;
    end else begin
      res_o  <= res_n;
      zero_o <= (res_n == '0);
      ovf_o  <= ovf_n;
    end
  end

  AST_LSH_FAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_LSH && big) |=> (res_o == '0)); // R3
  AST_ASH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ASH && big && neg) |=> (res_o == {W{$past(a_i[W-1])}})); // R4
  AST_ROT_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ROT) |=> ($countones(res_o) == $countones($past(a_i)))); // R5
  AST_BTST_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_BTST) |=> (res_o[W-1:1] == '0)); // R7
  AST_FEXT_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_FEXT) |=> ((res_o & ~$past(fmask)) == '0)); // R9
  AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_EXP) |=> (res_o < W)); // R11
  AST_OVF_ONLY_ASH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != OP_ASH) |=> !ovf_o); // R12
endmodule

// File: tb/fieldshift_tb.sv
module fieldshift_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0, c_i = '0;
  logic [31:0] res_o;
  logic        zero_o, ovf_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  fieldshift u_dut (.clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
                    .c_i(c_i), .res_o(res_o), .zero_o(zero_o), .ovf_o(ovf_o));

  always #4 clk = ~clk;

  // {req, op, a, b, c, expected result, zero, ovf}
  localparam int NV = 36;
  localparam logic [137:0] VEC [NV] = '{
    {4'd3,  4'd0,  32'h000000F0, 32'h00000004, 32'h0, 32'h00000F00, 1'b0, 1'b0}, // R3
    {4'd3,  4'd0,  32'h000000F0, 32'h000000FC, 32'h0, 32'h0000000F, 1'b0, 1'b0}, // R3
    {4'd3,  4'd0,  32'hFFFFFFFF, 32'h00000020, 32'h0, 32'h00000000, 1'b1, 1'b0}, // R3
    {4'd3,  4'd0,  32'hFFFFFFFF, 32'h000000E0, 32'h0, 32'h00000000, 1'b1, 1'b0}, // R3
    {4'd3,  4'd0,  32'h80000001, 32'hFFFF001F, 32'h0, 32'h80000000, 1'b0, 1'b0}, // R3
    {4'd4,  4'd1,  32'h80000000, 32'h000000FC, 32'h0, 32'hF8000000, 1'b0, 1'b0}, // R4
    {4'd4,  4'd1,  32'h80000000, 32'h000000D8, 32'h0, 32'hFFFFFFFF, 1'b0, 1'b0}, // R4
    {4'd4,  4'd1,  32'h40000000, 32'h00000001, 32'h0, 32'h80000000, 1'b0, 1'b1}, // R4
    {4'd4,  4'd1,  32'h20000000, 32'h00000001, 32'h0, 32'h40000000, 1'b0, 1'b0}, // R4
    {4'd4,  4'd1,  32'h7FFFFFFF, 32'h00000080, 32'h0, 32'h00000000, 1'b1, 1'b0}, // R4
    {4'd12, 4'd1,  32'h80000000, 32'h00000020, 32'h0, 32'h00000000, 1'b1, 1'b1}, // R12
    {4'd5,  4'd2,  32'h80000001, 32'h00000001, 32'h0, 32'h00000003, 1'b0, 1'b0}, // R5
    {4'd5,  4'd2,  32'h80000001, 32'h000000FF, 32'h0, 32'hC0000000, 1'b0, 1'b0}, // R5
    {4'd5,  4'd2,  32'h12345678, 32'h00000020, 32'h0, 32'h12345678, 1'b0, 1'b0}, // R5
    {4'd6,  4'd3,  32'h00000000, 32'h0000001F, 32'h0, 32'h80000000, 1'b0, 1'b0}, // R6
    {4'd6,  4'd4,  32'hFFFFFFFF, 32'h00000000, 32'h0, 32'hFFFFFFFE, 1'b0, 1'b0}, // R6
    {4'd6,  4'd5,  32'h000000FF, 32'h00000004, 32'h0, 32'h000000EF, 1'b0, 1'b0}, // R6
    {4'd7,  4'd6,  32'h00000100, 32'h00000008, 32'h0, 32'h00000001, 1'b0, 1'b0}, // R7
    {4'd7,  4'd6,  32'hFFFFFEFF, 32'h00000008, 32'h0, 32'h00000000, 1'b1, 1'b0}, // R7
    {4'd9,  4'd7,  32'h12345678, 32'h00000808, 32'h0, 32'h00000056, 1'b0, 1'b0}, // R9
    {4'd8,  4'd7,  32'hF0000000, 32'h0000081C, 32'h0, 32'h0000000F, 1'b0, 1'b0}, // R8
    {4'd8,  4'd7,  32'hFFFFFFFF, 32'h00000004, 32'h0, 32'h00000000, 1'b1, 1'b0}, // R8
    {4'd9,  4'd8,  32'h00000F00, 32'h00000408, 32'h0, 32'hFFFFFFFF, 1'b0, 1'b0}, // R9
    {4'd9,  4'd8,  32'h00000700, 32'h00000408, 32'h0, 32'h00000007, 1'b0, 1'b0}, // R9
    {4'd8,  4'd8,  32'h80000000, 32'h00003F1F, 32'h0, 32'hFFFFFFFF, 1'b0, 1'b0}, // R8
    {4'd10, 4'd9,  32'h000000AB, 32'h00000808, 32'hFFFFFFFF, 32'hFFFFABFF, 1'b0, 1'b0}, // R10
    {4'd8,  4'd9,  32'hFFFFFFFF, 32'h0000081C, 32'h00000000, 32'hF0000000, 1'b0, 1'b0}, // R8
    {4'd10, 4'd9,  32'hFFFFFFFF, 32'h00000000, 32'h12345678, 32'h12345678, 1'b0, 1'b0}, // R10
    {4'd10, 4'd9,  32'h00000005, 32'h00002000, 32'h00000000, 32'h00000005, 1'b0, 1'b0}, // R10
    {4'd11, 4'd10, 32'h00000000, 32'h0, 32'h0, 32'h0000001F, 1'b0, 1'b0}, // R11
    {4'd11, 4'd10, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0000001F, 1'b0, 1'b0}, // R11
    {4'd11, 4'd10, 32'h40000000, 32'h0, 32'h0, 32'h00000000, 1'b1, 1'b0}, // R11
    {4'd11, 4'd10, 32'h00000001, 32'h0, 32'h0, 32'h0000001E, 1'b0, 1'b0}, // R11
    {4'd11, 4'd10, 32'hFFFFFFFE, 32'h0, 32'h0, 32'h0000001E, 1'b0, 1'b0}, // R11
    {4'd11, 4'd10, 32'h80000000, 32'h0, 32'h0, 32'h00000000, 1'b1, 1'b0}, // R11
    {4'd12, 4'd12, 32'hCAFEF00D, 32'h0, 32'h0, 32'hCAFEF00D, 1'b0, 1'b0}  // R12
  };

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 res", res_o, 32'h0);
    check("R1 zero", {31'b0, zero_o}, 32'h1);
    check("R1 ovf", {31'b0, ovf_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [137:0] v;
      string tag;
      v = VEC[i];
      @(negedge clk);
      op_i = v[133:130]; a_i = v[129:98]; b_i = v[97:66]; c_i = v[65:34];
      @(posedge clk);
      #2;
      tag = $sformatf("R%0d vec %0d", v[137:134], i);
      check({tag, " res"}, res_o, v[33:2]);
      check({tag, " zero"}, {31'b0, zero_o}, {31'b0, v[1]});
      check({tag, " ovf"}, {31'b0, ovf_o}, {31'b0, v[0]});
    end

    // R2: output holds until the edge, then shows the new result
    @(negedge clk);
    op_i = 4'd0; a_i = 32'h1; b_i = 32'h1; c_i = '0;
    @(posedge clk); #2;
    check("R2 first", res_o, 32'h2);
    @(negedge clk);
    b_i = 32'h3;
    #1;
    check("R2 hold", res_o, 32'h2);
    @(posedge clk); #2;
    check("R2 update", res_o, 32'h8);

    // R1: reset mid-run clears the outputs
    @(negedge clk);
    op_i = 4'd1; a_i = 32'h40000000; b_i = 32'h1;
    @(posedge clk); #2;
    check("R4 ovf before reset", {31'b0, ovf_o}, 32'h1);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #2;
    check("R1 res mid", res_o, 32'h0);
    check("R1 zero mid", {31'b0, zero_o}, 32'h1);
    check("R1 ovf mid", {31'b0, ovf_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check("R4 after reset", res_o, 32'h80000000);
    finish_run();
  end
endmodule